// File: doc/BRIEF.md
# Dual-Channel Disk Port Address Decoder

This block sits between a host programmed-I/O request stream and four drive register ports arranged as two channels of two drives each. Every host request is matched against five relocatable address windows: a command window and a control window for each channel, plus one window for the bus-master registers. A match yields a window-relative offset, a block type and a channel, which are shown on plain decode outputs so that a neighbouring bus-master register file can act on its own window.

Command and control accesses are forwarded to one drive port. The drive is picked by the channel and by a device-select bit that the block keeps for each channel. A byte write to the drive/head register of a command window updates that bit before the write is forwarded, so the write reaches the newly selected drive. A 32-bit access to the data register becomes two 16-bit drive transfers. Every request ends with exactly one response that carries read data and an error flag.

The host side is valid/ready. `req_ready` is high only while the block is idle, and one request is in flight at a time. The drive port holds `drv_valid` and its payload until `drv_ready`, and `drv_rdata` is sampled in the handshake cycle. The response holds `rsp_valid`, `rsp_err` and `rsp_rdata` until `rsp_ready`.

Top module: `ide_chan_decoder`

## Requirements
- R1: `win_base` packs five window bases, each AW bits wide, at index 0 primary command (8 bytes), 1 primary control (4 bytes), 2 secondary command (8 bytes), 3 secondary control (4 bytes) and 4 bus-master (16 bytes). An address in [base, base+size) hits that window. The lowest index wins when windows overlap. `dec_off` is the address minus the base, and `dec_blk` reads 0 for command, 1 for control, 2 for bus-master and 3 for no hit.
- R2: A base of zero leaves its window unmapped, so no address hits it, not even address 0.
- R3: In the bus-master window, an offset below 8 gives `dec_chan`=0 and an offset of 8 or more gives `dec_chan`=1. Bus-master accesses make no drive transfer and respond with error 0 and data 0.
- R4: An address that hits no window responds with `rsp_err`=1 and makes no drive transfer, whether `io_en` is high or low.
- R5: The drive index is 2×channel + that channel's select bit, and both select bits are 0 after reset. A byte write (size 0) to command-window offset 6 sets the channel's bit from data bit 4, and the same write goes to the newly selected drive.
- R6: While `io_en` is low, a request that hits a window makes no drive transfer, leaves both select bits unchanged, and responds with error 0 and data 0.
- R7: A 16-bit access (size 1) to the data register at command offset 0 makes one drive transfer. A 32-bit access (size 2) makes two transfers: data bits 15:0 first, then bits 31:16. A 32-bit read returns {second response, first response}.
- R8: Command offsets other than 0, and all control offsets, accept only byte accesses (size 0), which read as the drive's low byte zero-extended. Any other size, or size 0 or 3 on the data register, responds with error 1 and makes no drive transfer.
- R9: An access to a drive whose `drv_present` bit is 0 makes no transfer and responds with error 0 and data 0. A write to the select register still updates the select bit.
- R10: `req_ready` is low from acceptance until the response handshake. `drv_valid` and its payload hold until `drv_ready`, and the response holds until `rsp_ready`.
- R11: After reset, `req_ready` is 1 and `drv_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | I/O decoding enable |
| win_base | input | 5*AW | Window bases, index 0 in the low bits |
| drv_present | input | 4 | One bit per drive port, set when the drive exists |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Request address |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 illegal |
| req_wdata | input | 32 | Write data |
| dec_hit | output | 1 | Current address hits a window |
| dec_blk | output | 2 | Block type of the current address |
| dec_chan | output | 1 | Channel of the current address |
| dec_off | output | OFW | Window-relative offset |
| drv_valid | output | 1 | Drive transfer valid |
| drv_ready | input | 1 | Drive accepts the transfer |
| drv_write | output | 1 | Drive transfer is a write |
| drv_idx | output | 2 | Target drive port |
| drv_ctrl | output | 1 | 1 control window, 0 command window |
| drv_off | output | OFW | Register offset in the window |
| drv_wdata | output | 16 | Write data for this transfer |
| drv_rdata | input | 16 | Drive read data, valid in the handshake cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_err | output | 1 | Decode or size error |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench sends sequences that exercise each case in turn. Byte command and control accesses on both channels check the window and offset arithmetic. A select write followed by reads shows that the drive index follows the latched bit. Data-register accesses of 16 and 32 bits tell single transfers apart from split ones and check the half order and read assembly. Bus-master offsets on both sides of 8 and at the window end check the channel split and the boundary. Misses, zero bases, overlapping bases and illegal sizes cover the error paths. Accesses with I/O disabled and accesses to an absent drive must leave the select state as a later read shows it. Drive and response readiness follow a stalling pattern throughout, so every transfer meets back-pressure.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  typedef enum logic [1:0] {
    BLK_CMD  = 2'd0,
    BLK_CTRL = 2'd1,
    BLK_BM   = 2'd2,
    BLK_NONE = 2'd3
  } blk_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LO   = 2'd1,
    S_HI   = 2'd2,
    S_RSP  = 2'd3
  } seq_st_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam int NUM_WIN = 5;
endpackage

// File: rtl/ide_win_dec.sv
module ide_win_dec
  import ide_dec_pkg::*;
#(
  parameter int AW         = 16,
  parameter int CMD_SIZE   = 8,
  parameter int CTRL_SIZE  = 4,
  parameter int BM_SIZE    = 16,
  parameter int BM_SEC_OFF = 8,
  parameter int OFW        = 4
) (
  input  logic [AW-1:0]         addr,
  input  logic [NUM_WIN*AW-1:0] win_base,
  output logic                  hit,
  output blk_e                  blk,
  output logic                  chan,
  output logic [OFW-1:0]        off
);
  function automatic int win_size(input int i);
    if (i == NUM_WIN - 1) return BM_SIZE;
    return (i % 2 == 0) ? CMD_SIZE : CTRL_SIZE;
  endfunction

  logic [NUM_WIN-1:0]          hit_w;
  logic [NUM_WIN-1:0][OFW-1:0] off_w;

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    logic [AW-1:0] base_g;
    logic [AW-1:0] diff_g;
    logic [AW:0]   lim_g;
    assign base_g = win_base[gi*AW +: AW];
    assign lim_g  = {1'b0, base_g} + (AW+1)'(win_size(gi));
    assign diff_g = addr - base_g;
    assign hit_w[gi] = (base_g != '0) && (addr >= base_g) &&
                       ({1'b0, addr} < lim_g);
    assign off_w[gi] = diff_g[OFW-1:0];
  end

  // lowest window index takes priority
  always_comb begin
    hit  = 1'b0;
    blk  = BLK_NONE;
    chan = 1'b0;
    off  = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_w[i]) begin
        hit = 1'b1;
        off = off_w[i];
        if (i == NUM_WIN - 1) begin
          blk  = BLK_BM;
          chan = (off_w[i] >= OFW'(BM_SEC_OFF));
        end else begin
          blk  = (i % 2 == 0) ? BLK_CMD : BLK_CTRL;
          chan = (i >= 2);
        end
      end
    end
  end
endmodule

// File: rtl/ide_dev_sel.sv
module ide_dev_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_en,
  input  logic       set_chan,
  input  logic       set_val,
  output logic [1:0] dev
);
  for (genvar gc = 0; gc < 2; gc++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n)                                dev[gc] <= 1'b0;
      else if (set_en && (set_chan == 1'(gc)))   dev[gc] <= set_val;
    end
  end

  // R5: select bits move only on a select write
  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en |=> $stable(dev));
endmodule

// File: rtl/ide_xfer_seq.sv
module ide_xfer_seq
  import ide_dec_pkg::*;
#(
  parameter int OFW      = 4,
  parameter int DATA_OFF = 0,
  parameter int SEL_OFF  = 6,
  parameter int SEL_BIT  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           io_en,
  input  logic [3:0]     drv_present,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [1:0]     req_size,
  input  logic [31:0]    req_wdata,
  input  logic           dec_hit,
  input  blk_e           dec_blk,
  input  logic           dec_chan,
  input  logic [OFW-1:0] dec_off,
  input  logic [1:0]     dev,
  output logic           sel_set,
  output logic           sel_chan,
  output logic           sel_val,
  output logic           drv_valid,
  input  logic           drv_ready,
  output logic           drv_write,
  output logic [1:0]     drv_idx,
  output logic           drv_ctrl,
  output logic [OFW-1:0] drv_off,
  output logic [15:0]    drv_wdata,
  input  logic [15:0]    drv_rdata,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic           rsp_err,
  output logic [31:0]    rsp_rdata
);
  seq_st_e        st;
  logic           r_write, r_ctrl, r_wide, r_err;
  logic [1:0]     r_idx, r_size;
  logic [OFW-1:0] r_off;
  logic [31:0]    r_wdata, r_rdata;

  logic       is_drv, is_data, sz_bad, e_err, cur_dev, fwd;
  logic [1:0] n_idx;

  assign req_ready = (st == S_IDLE);

  always_comb begin
    is_drv  = dec_hit && (dec_blk == BLK_CMD || dec_blk == BLK_CTRL);
    is_data = dec_hit && (dec_blk == BLK_CMD) && (dec_off == OFW'(DATA_OFF));
    sz_bad  = is_data ? (req_size == SZ_BYTE || req_size == 2'd3)
                      : (req_size != SZ_BYTE);
    e_err   = !dec_hit || (io_en && is_drv && sz_bad);
    sel_set = req_valid && req_ready && io_en && dec_hit &&
              (dec_blk == BLK_CMD) && (dec_off == OFW'(SEL_OFF)) &&
              req_write && (req_size == SZ_BYTE);
    sel_chan = dec_chan;
    sel_val  = req_wdata[SEL_BIT];
    cur_dev  = sel_set ? sel_val : dev[dec_chan];
    n_idx    = {dec_chan, cur_dev};
    fwd      = io_en && is_drv && !e_err && drv_present[n_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_write <= 1'b0;
      r_ctrl  <= 1'b0;
      r_wide  <= 1'b0;
      r_err   <= 1'b0;
      r_idx   <= '0;
      r_size  <= '0;
      r_off   <= '0;
      r_wdata <= '0;
      r_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          r_write <= req_write;
          r_ctrl  <= (dec_blk == BLK_CTRL);
          r_wide  <= is_data && (req_size == SZ_WORD);
          r_err   <= e_err;
          r_idx   <= n_idx;
          r_size  <= req_size;
          r_off   <= dec_off;
          r_wdata <= req_wdata;
          r_rdata <= '0;
          st      <= fwd ? S_LO : S_RSP;
        end
        S_LO: if (drv_ready) begin
          if (!r_write)
            r_rdata[15:0] <= (r_size == SZ_BYTE) ? {8'h00, drv_rdata[7:0]}
                                                 : drv_rdata;
          st <= r_wide ? S_HI : S_RSP;
        end
        S_HI: if (drv_ready) begin
          if (!r_write) r_rdata[31:16] <= drv_rdata;
          st <= S_RSP;
        end
        S_RSP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign drv_valid = (st == S_LO) || (st == S_HI);
  assign drv_write = r_write;
  assign drv_idx   = r_idx;
  assign drv_ctrl  = r_ctrl;
  assign drv_off   = r_off;
  assign drv_wdata = (st == S_HI) ? r_wdata[31:16] : r_wdata[15:0];
  assign rsp_valid = (st == S_RSP);
  assign rsp_err   = r_err;
  assign rsp_rdata = r_rdata;

  p_drv_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drv_valid && !drv_ready |=> drv_valid && $stable(drv_idx) &&
                                $stable(drv_off) && $stable(drv_wdata));
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));
  p_wide_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_valid && drv_ready && (st == S_LO) && r_wide |=> drv_valid && $stable(drv_idx));
  p_io_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !io_en |=> !drv_valid);
  p_miss_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !dec_hit |=> rsp_valid && rsp_err);
endmodule

// File: rtl/ide_chan_decoder.sv
module ide_chan_decoder
  import ide_dec_pkg::*;
#(
  parameter int AW         = 16,
  parameter int CMD_SIZE   = 8,
  parameter int CTRL_SIZE  = 4,
  parameter int BM_SIZE    = 16,
  parameter int BM_SEC_OFF = 8,
  parameter int DATA_OFF   = 0,
  parameter int SEL_OFF    = 6,
  parameter int SEL_BIT    = 4,
  localparam int MAX_SZ    = (BM_SIZE > CMD_SIZE) ?
                             ((BM_SIZE > CTRL_SIZE) ? BM_SIZE : CTRL_SIZE) :
                             ((CMD_SIZE > CTRL_SIZE) ? CMD_SIZE : CTRL_SIZE),
  localparam int OFW       = (MAX_SZ > 2) ? $clog2(MAX_SZ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_en,
  input  logic [5*AW-1:0]   win_base,
  input  logic [3:0]        drv_present,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              dec_hit,
  output logic [1:0]        dec_blk,
  output logic              dec_chan,
  output logic [OFW-1:0]    dec_off,
  output logic              drv_valid,
  input  logic              drv_ready,
  output logic              drv_write,
  output logic [1:0]        drv_idx,
  output logic              drv_ctrl,
  output logic [OFW-1:0]    drv_off,
  output logic [15:0]       drv_wdata,
  input  logic [15:0]       drv_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata
);
  blk_e       blk_w;
  logic [1:0] dev_w;
  logic       sel_set_w, sel_chan_w, sel_val_w;

  ide_win_dec #(
    .AW(AW), .CMD_SIZE(CMD_SIZE), .CTRL_SIZE(CTRL_SIZE), .BM_SIZE(BM_SIZE),
    .BM_SEC_OFF(BM_SEC_OFF), .OFW(OFW)
  ) u_dec (
    .addr(req_addr), .win_base(win_base),
    .hit(dec_hit), .blk(blk_w), .chan(dec_chan), .off(dec_off)
  );

  assign dec_blk = blk_w;

  ide_dev_sel u_sel (
    .clk(clk), .rst_n(rst_n), .set_en(sel_set_w),
    .set_chan(sel_chan_w), .set_val(sel_val_w), .dev(dev_w)
  );

  ide_xfer_seq #(
    .OFW(OFW), .DATA_OFF(DATA_OFF), .SEL_OFF(SEL_OFF), .SEL_BIT(SEL_BIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .drv_present(drv_present),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_wdata(req_wdata),
    .dec_hit(dec_hit), .dec_blk(blk_w), .dec_chan(dec_chan), .dec_off(dec_off),
    .dev(dev_w), .sel_set(sel_set_w), .sel_chan(sel_chan_w), .sel_val(sel_val_w),
    .drv_valid(drv_valid), .drv_ready(drv_ready), .drv_write(drv_write),
    .drv_idx(drv_idx), .drv_ctrl(drv_ctrl), .drv_off(drv_off),
    .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: tb/ide_chan_decoder_tb_top.sv
`timescale 1ns/1ps
module ide_chan_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_en = 1'b0;
  logic [79:0] win_base = '0;
  logic [3:0]  drv_present = 4'b0111;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, dec_hit, dec_chan;
  logic [1:0]  dec_blk;
  logic [3:0]  dec_off, drv_off;
  logic        drv_valid, drv_write, drv_ctrl;
  logic        drv_ready = 1'b0, rsp_ready = 1'b0;
  logic [1:0]  drv_idx;
  logic [15:0] drv_wdata, drv_rdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int nchk = 0, nerr = 0, gcyc = 0, nhs = 0;
  bit mdev[2] = '{0, 0};

  always #2 clk = ~clk;

  ide_chan_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .win_base(win_base),
    .drv_present(drv_present), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .dec_hit(dec_hit), .dec_blk(dec_blk),
    .dec_chan(dec_chan), .dec_off(dec_off), .drv_valid(drv_valid),
    .drv_ready(drv_ready), .drv_write(drv_write), .drv_idx(drv_idx),
    .drv_ctrl(drv_ctrl), .drv_off(drv_off), .drv_wdata(drv_wdata),
    .drv_rdata(drv_rdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic set_base(input int i, input logic [15:0] v);
    win_base[i*16 +: 16] = v;
  endtask

  // reference decode, written from the window table in the requirements
  task automatic mdec(input int a, output bit hit, output int blk,
                      output int ch, output int off);
    int sz[5] = '{8, 4, 8, 4, 16};
    hit = 0; blk = 3; ch = 0; off = 0;
    for (int i = 0; i < 5; i++) begin
      int b = int'(win_base[i*16 +: 16]);
      if (!hit && b != 0 && a >= b && a < b + sz[i]) begin
        hit = 1;
        off = a - b;
        blk = (i == 4) ? 2 : i % 2;
        ch  = (i < 4) ? i / 2 : int'(off >= 8);
      end
    end
  endtask

  task automatic access(input bit w, input int addr, input int size,
                        input logic [31:0] wd, input string rq);
    bit hit, err, fwd, is_drv, is_data, szbad, done;
    int blk, ch, off, idx, nexp, n;
    logic [15:0] got[2];
    logic [31:0] exp_d;
    mdec(addr, hit, blk, ch, off);
    is_drv  = hit && blk < 2;
    is_data = hit && blk == 0 && off == 0;
    szbad   = is_data ? (size == 0 || size == 3) : (size != 0);
    err     = !hit || (io_en && is_drv && szbad);
    if (io_en && hit && blk == 0 && off == 6 && w && size == 0) mdev[ch] = wd[4];
    idx  = ch * 2 + int'(mdev[ch]);
    fwd  = io_en && is_drv && !err && drv_present[idx];
    nexp = fwd ? ((is_data && size == 2) ? 2 : 1) : 0;

    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = 16'(addr);
    req_size = 2'(size); req_wdata = wd;
    #1;
    chk(rq, "req_ready idle", {31'b0, req_ready}, 32'd1);
    chk(rq, "dec_hit", {31'b0, dec_hit}, {31'b0, hit});
    chk(rq, "dec_blk", {30'b0, dec_blk}, 32'(blk));
    if (hit) begin
      chk(rq, "dec_chan", {31'b0, dec_chan}, 32'(ch));
      chk(rq, "dec_off", {28'b0, dec_off}, 32'(off));
    end

    n = 0; done = 0; got[0] = '0; got[1] = '0;
    for (int c = 0; c < 60 && !done; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      gcyc++;
      drv_ready = (gcyc % 3) != 1;
      rsp_ready = (gcyc % 4) != 0;
      drv_rdata = 16'hC000 + 16'(nhs) * 16'h0111;
      #1;
      chk("R10", "req_ready busy", {31'b0, req_ready}, 32'd0);
      if (drv_valid && drv_ready) begin
        chk(rq, "drive transfer expected", 32'(n < nexp), 32'd1);
        chk(rq, "drv_idx", {30'b0, drv_idx}, 32'(idx));
        chk(rq, "drv_write", {31'b0, drv_write}, {31'b0, w});
        chk(rq, "drv_ctrl", {31'b0, drv_ctrl}, 32'(blk == 1));
        chk(rq, "drv_off", {28'b0, drv_off}, 32'(off));
        chk(rq, "drv_wdata", {16'b0, drv_wdata},
            {16'b0, (n == 0) ? wd[15:0] : wd[31:16]});
        if (n < 2) got[n] = drv_rdata;
        n++; nhs++;
      end
      if (rsp_valid && rsp_ready) begin
        chk(rq, "drive transfer count", 32'(n), 32'(nexp));
        if (!w && nexp > 0)
          exp_d = (size == 0) ? {24'b0, got[0][7:0]} :
                  (size == 1) ? {16'b0, got[0]} : {got[1], got[0]};
        else
          exp_d = '0;
        chk(rq, "rsp_err", {31'b0, rsp_err}, {31'b0, err});
        chk(rq, "rsp_rdata", rsp_rdata, exp_d);
        done = 1;
      end
    end
    if (!done) chk(rq, "response timeout", 32'd0, 32'd1);
  endtask

  initial begin
    #(4 * 100000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    set_base(0, 16'h01F0); set_base(1, 16'h03F4);
    set_base(2, 16'h0170); set_base(3, 16'h0374);
    set_base(4, 16'hC000);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11", "reset req_ready", {31'b0, req_ready}, 32'd1);
    chk("R11", "reset drv_valid", {31'b0, drv_valid}, 32'd0);
    chk("R11", "reset rsp_valid", {31'b0, rsp_valid}, 32'd0);

    // R6: decoding disabled
    io_en = 1'b0;
    access(1, 16'h01F6, 0, 32'h10, "R6");
    access(0, 16'h01F2, 0, 0, "R6");
    access(0, 16'h0100, 0, 0, "R4");
    io_en = 1'b1;
    access(0, 16'h01F2, 0, 0, "R6");   // still drive 0
    // R5 select and forward to new drive
    access(1, 16'h01F6, 0, 32'h000000F0, "R5");
    access(0, 16'h01F3, 0, 0, "R5");
    access(0, 16'h01F0, 1, 0, "R7");
    access(0, 16'h03F6, 0, 0, "R1");
    access(1, 16'h01F6, 0, 32'h0000000A, "R5");
    access(0, 16'h01F7, 0, 0, "R1");
    // R7 split transfers on secondary
    access(1, 16'h0170, 2, 32'hDEADBEEF, "R7");
    access(0, 16'h0170, 2, 0, "R7");
    access(1, 16'h0170, 1, 32'h00001234, "R7");
    // R9 absent drive 3
    access(1, 16'h0176, 0, 32'h10, "R9");
    access(0, 16'h0376, 0, 0, "R9");
    access(0, 16'h0170, 2, 0, "R9");
    access(1, 16'h0176, 0, 32'h00, "R9");
    access(0, 16'h0372, 0, 0, "R9");
    // R3 bus-master channel split and boundaries
    access(0, 16'hC002, 0, 0, "R3");
    access(0, 16'hC007, 0, 0, "R3");
    access(0, 16'hC008, 0, 0, "R3");
    access(1, 16'hC00F, 2, 32'h5555AAAA, "R3");
    access(0, 16'hC010, 0, 0, "R4");
    // R4 misses and window edges
    access(0, 16'h0100, 0, 0, "R4");
    access(0, 16'h01F8, 0, 0, "R4");
    access(1, 16'h03F3, 0, 32'h1, "R4");
    // R8 size rules
    access(0, 16'h01F2, 1, 0, "R8");
    access(0, 16'h01F0, 0, 0, "R8");
    access(1, 16'h01F0, 3, 32'h1, "R8");
    access(0, 16'h03F6, 2, 0, "R8");
    access(0, 16'h0373, 0, 0, "R8");
    // R2 zero base
    set_base(1, 16'h0000);
    access(0, 16'h0002, 0, 0, "R2");
    access(0, 16'h03F6, 0, 0, "R2");
    set_base(1, 16'h03F4);
    // R1 overlap priority
    set_base(2, 16'h01F0);
    access(0, 16'h01F2, 0, 0, "R1");
    set_base(2, 16'h0170);
    access(0, 16'h0174, 0, 0, "R1");

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule